// File: doc/BRIEF.md
# Supply Undervoltage Reset Sequencer

This block turns two digitized comparator flags on a supervised supply rail into an active-low reset for a microcontroller. One flag reports that the rail is above the upper (release) threshold, the other that it has fallen below the lower (assert) threshold. Because the two thresholds differ, the block has hysteresis: the rail must climb past the higher level to release reset, and must sag below the lower level to assert it again.

Reset starts low after power-up and after any undervoltage. It is released only after a fixed delay, counted in clock cycles, during which the rail stays above the upper threshold. Once reset is high, brief dips below the lower threshold are filtered. Reset is asserted only after a dip lasts for a whole blanking interval, and that interval fits inside a bounded reaction time. An enable input pulls reset low at once and restarts the whole sequence. A one-cycle strobe marks each release so that a downstream watchdog can begin its own timing. All times are parameters in clock cycles.

Top module: `vsup_rst_seq`

## Requirements
- R1: While `por_n` is low, and after it rises, `rst_n` and `rel_pulse` are 0. `rst_n` stays 0 until the release condition of R2 is met.
- R2: While reset is low and enabled, `rst_n` rises after the clock edge that samples the DELAY_CYC-th consecutive cycle with `sup_above_hi`=1 and `sup_below_lo`=0. Counting starts at the first such sampled cycle.
- R3: While reset is high, `rst_n` falls after the clock edge that samples the BLANK_CYC-th consecutive cycle with `sup_below_lo`=1. BLANK_CYC must not exceed REACT_CYC, so no run of undervoltage samples longer than REACT_CYC leaves reset high.
- R4: A run of `sup_below_lo`=1 samples shorter than BLANK_CYC, while reset is high, leaves `rst_n` high. The next run starts its count from zero.
- R5: While the release delay is running, any sampled cycle without the release condition restarts the delay from zero. It does not resume from where it stopped.
- R6: With `en`=0, `rst_n` and `rel_pulse` are 0 in the same cycle, before any clock edge, and all counters clear. After `en` returns to 1, a full R2 delay is needed again.
- R7: `rel_pulse` is 1 for exactly the first clock cycle in which `rst_n` is 1 after a release, and 0 at every other time.
- R8: With both flags 0 (rail between the two thresholds), a high reset stays high, and a low reset does not advance toward release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| en | input | 1 | Block enable; 0 forces reset low |
| sup_above_hi | input | 1 | Rail above the upper (release) threshold |
| sup_below_lo | input | 1 | Rail below the lower (assert) threshold |
| rst_n | output | 1 | Reset request to the microcontroller, active low |
| rel_pulse | output | 1 | One-cycle strobe on each release of reset |

## Verification
The hardest situations to reach from the ports are the ones where one counter is interrupted exactly at its boundary. Examples are a dip of BLANK_CYC-1 cycles followed by a dip of exactly BLANK_CYC cycles, and an undervoltage landing a few cycles before the release delay would finish. Directed sequences place these edges cycle by cycle. Random stimulus then mixes dip lengths around the blanking limit, in-between-threshold stretches and occasional enable drops, with a bench reference model predicting every output cycle. The enable drop is also checked between clock edges to confirm that reset falls without waiting for a clock.

// File: rtl/vsup_rst_seq.sv
module vsup_rst_seq #(
  parameter int DELAY_CYC = 16500,
  parameter int BLANK_CYC = 7,
  parameter int REACT_CYC = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  input  logic sup_above_hi,
  input  logic sup_below_lo,
  output logic rst_n,
  output logic rel_pulse
);
  localparam int DW = $clog2(DELAY_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  generate
    if (BLANK_CYC < 1 || DELAY_CYC < 1 || BLANK_CYC > REACT_CYC) begin : g_bad_cfg
      $error("vsup_rst_seq: invalid timing parameters");
    end
  endgenerate

  logic          live_q;
  logic          rel_q;
  logic [DW-1:0] dly_q;
  logic [BW-1:0] blk_q;

  wire good     = sup_above_hi & ~sup_below_lo;
  wire dly_done = good && (dly_q == DW'(DELAY_CYC - 1));
  wire blk_done = sup_below_lo && (blk_q == BW'(BLANK_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      live_q <= 1'b0;
      rel_q  <= 1'b0;
      dly_q  <= '0;
      blk_q  <= '0;
    end else if (!en) begin
      live_q <= 1'b0;
      rel_q  <= 1'b0;
      dly_q  <= '0;
      blk_q  <= '0;
    end else if (!live_q) begin
      blk_q <= '0;
      rel_q <= 1'b0;
      if (!good) begin
        dly_q <= '0;
      end else if (dly_done) begin
        dly_q  <= '0;
        live_q <= 1'b1;
        rel_q  <= 1'b1;
      end else begin
        dly_q <= dly_q + 1'b1;
      end
    end else begin
      rel_q <= 1'b0;
      dly_q <= '0;
      if (!sup_below_lo) begin
        blk_q <= '0;
      end else if (blk_done) begin
        blk_q  <= '0;
        live_q <= 1'b0;
      end else begin
        blk_q <= blk_q + 1'b1;
      end
    end
  end

  assign rst_n     = live_q & en;
  assign rel_pulse = rel_q & en;
endmodule

// File: rtl/vsup_rst_seq_chk.sv
module vsup_rst_seq_chk #(
  parameter int REACT_CYC = 10
) (
  input logic clk,
  input logic por_n,
  input logic en,
  input logic sup_above_hi,
  input logic sup_below_lo,
  input logic rst_n,
  input logic rel_pulse
);
  localparam int RW = $clog2(REACT_CYC + 2);
  logic [RW-1:0] uv_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) uv_run <= '0;
    else if (rst_n && sup_below_lo) uv_run <= uv_run + 1'b1;
    else uv_run <= '0;
  end

  AST_REACT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    uv_run <= RW'(REACT_CYC)); // R3
  AST_FALL_NEEDS_UV: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(rst_n) && en && $past(en)) |-> $past(sup_below_lo)); // R3
  AST_RISE_NEEDS_HI: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> ($past(sup_above_hi) && !$past(sup_below_lo))); // R2
  AST_REENABLE_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (en && !$past(en)) |-> !rst_n); // R6
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> rel_pulse); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    rel_pulse |=> !rel_pulse); // R7
  AST_STROBE_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
    rel_pulse |-> rst_n); // R7
endmodule

bind vsup_rst_seq vsup_rst_seq_chk #(.REACT_CYC(REACT_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .en(en), .sup_above_hi(sup_above_hi),
  .sup_below_lo(sup_below_lo), .rst_n(rst_n), .rel_pulse(rel_pulse)
);

// File: tb/vsup_rst_seq_test.sv
`timescale 1ns/1ps
module vsup_rst_seq_test;
  localparam int D = 20;
  localparam int B = 5;
  localparam int RC = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic en = 1'b0;
  logic hi = 1'b0;
  logic lo = 1'b1;
  logic rst_n, rel_pulse;

  int checks = 0;
  int fails = 0;

  logic m_rst = 1'b0;
  logic m_pulse = 1'b0;
  int   run = 0;
  int   blk = 0;

  always #4 clk = ~clk;

  vsup_rst_seq #(.DELAY_CYC(D), .BLANK_CYC(B), .REACT_CYC(RC)) uut (
    .clk(clk), .por_n(por_n), .en(en), .sup_above_hi(hi),
    .sup_below_lo(lo), .rst_n(rst_n), .rel_pulse(rel_pulse)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_edge(input logic e, input logic h, input logic l);
    m_pulse = 1'b0;
    if (!e) begin
      m_rst = 1'b0; run = 0; blk = 0;
    end else if (!m_rst) begin
      blk = 0;
      if (h && !l) begin
        run++;
        if (run == D) begin m_rst = 1'b1; m_pulse = 1'b1; run = 0; end
      end else run = 0;
    end else begin
      run = 0;
      if (l) begin
        blk++;
        if (blk == B) begin m_rst = 1'b0; blk = 0; end
      end else blk = 0;
    end
  endfunction

  task automatic step(input logic e, input logic h, input logic l, input string tag);
    @(negedge clk);
    en = e; hi = h; lo = l;
    #1;
    chk(tag, rst_n, m_rst & e, "rst_n between edges");
    chk(tag, rel_pulse, m_pulse & e, "rel_pulse between edges");
    @(posedge clk);
    model_edge(e, h, l);
    #1;
    chk(tag, rst_n, m_rst & e, "rst_n");
    chk(tag, rel_pulse, m_pulse & e, "rel_pulse");
  endtask

  task automatic steps(input int n, input logic e, input logic h, input logic l, input string tag);
    for (int i = 0; i < n; i++) step(e, h, l, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    en = 1'b1; hi = 1'b1; lo = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", rst_n, 1'b0, "rst_n in power-on reset");
    chk("R1", rel_pulse, 1'b0, "rel_pulse in power-on reset");
    @(negedge clk);
    por_n = 1'b1;
    steps(8, 1'b1, 1'b0, 1'b1, "R1");
    steps(10, 1'b1, 1'b0, 1'b0, "R8");
    steps(D - 1, 1'b1, 1'b1, 1'b0, "R2");
    chk("R2", rst_n, 1'b0, "rst_n one cycle before release");
    step(1'b1, 1'b1, 1'b0, "R2");
    chk("R2", rst_n, 1'b1, "rst_n at exact release cycle");
    chk("R7", rel_pulse, 1'b1, "strobe on release");
    step(1'b1, 1'b1, 1'b0, "R7");
    chk("R7", rel_pulse, 1'b0, "strobe drops after one cycle");
    steps(4, 1'b1, 1'b1, 1'b0, "R2");
    steps(B - 1, 1'b1, 1'b0, 1'b1, "R4");
    chk("R4", rst_n, 1'b1, "short dip rejected");
    steps(2, 1'b1, 1'b1, 1'b0, "R4");
    steps(B - 1, 1'b1, 1'b0, 1'b1, "R4");
    chk("R4", rst_n, 1'b1, "second short dip counted afresh");
    step(1'b1, 1'b0, 1'b0, "R4");
    steps(B - 1, 1'b1, 1'b0, 1'b1, "R3");
    chk("R3", rst_n, 1'b1, "high one cycle before assert");
    step(1'b1, 1'b0, 1'b1, "R3");
    chk("R3", rst_n, 1'b0, "assert at exact blanking cycle");
    steps(D - 3, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b1, "R5");
    steps(D - 1, 1'b1, 1'b1, 1'b0, "R5");
    chk("R5", rst_n, 1'b0, "delay restarted, not resumed");
    step(1'b1, 1'b1, 1'b0, "R5");
    chk("R5", rst_n, 1'b1, "release after full fresh delay");
    steps(12, 1'b1, 1'b0, 1'b0, "R8");
    chk("R8", rst_n, 1'b1, "between thresholds holds high");
    step(1'b0, 1'b1, 1'b0, "R6");
    steps(2, 1'b0, 1'b1, 1'b0, "R6");
    steps(D - 1, 1'b1, 1'b1, 1'b0, "R6");
    chk("R6", rst_n, 1'b0, "re-enable needs full delay");
    step(1'b1, 1'b1, 1'b0, "R6");
    chk("R6", rst_n, 1'b1, "release after re-enable delay");

    for (int seg = 0; seg < 400; seg++) begin
      int kind = $urandom_range(0, 9);
      int len;
      if (kind < 4) begin
        len = $urandom_range(1, D + 4);
        steps(len, 1'b1, 1'b1, 1'b0, "R2");
      end else if (kind < 7) begin
        len = $urandom_range(1, B + 2);
        steps(len, 1'b1, 1'b0, 1'b1, "R3");
      end else if (kind < 9) begin
        len = $urandom_range(1, 6);
        steps(len, 1'b1, 1'b0, 1'b0, "R8");
      end else begin
        len = $urandom_range(1, 3);
        steps(len, 1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R6");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule